// File: doc/BRIEF.md
# Three-Digit Decimal Compression Codec

This block converts between binary-coded decimal digits and a dense decimal code. A digit from 0 to 7 is a *low-class* digit and takes a 3-bit field equal to its three low bits. An 8 or a 9 is a *top-class* digit and takes one bit, which is 0 for 8 and 1 for 9. A prefix that varies in length records which positions hold top-class digits. In wide mode, three digits (12 bits) pack into 10 bits. In narrow mode, two digits (8 bits) pack into 7 bits. The narrow layouts use the same prefix shapes as the wide layouts, so both modes share one datapath.

The translation itself is combinational. A single register stage follows it, so a request presented with `in_valid` gives its result one clock later. In encode direction, the block reports nibbles that are not decimal digits. In decode direction, it reports code words that lie outside the defined set. Sign handling, word packing and arithmetic belong to the blocks around this one.

Top module: `chd_codec`

## Requirements
- R1: Wide encode (`dir`=0, `narrow`=0) takes the most significant digit from `bcd_in[11:8]`, the middle digit from `bcd_in[7:4]` and the least significant digit from `bcd_in[3:0]`. Call their low-class fields p, q, r and their top-class bits P, Q, R. The 10-bit `code_out` follows the set of positions holding top-class digits: none → 0pppqqqrrr, first → 100Pqqqrrr, second → 101pppQrrr, third → 110pppqqqR, first+second → 11100PQrrr, first+third → 11101PqqqR, second+third → 11110pppQR, all three → 1111100PQR.
- R2: Narrow encode (`narrow`=1) takes the first digit from `bcd_in[7:4]` and the second from `bcd_in[3:0]`. It writes `code_out[6:0]` as 0pppqqq, 100Pqqq, 101pppQ or 11100PQ, and holds `code_out[9:7]` at 0.
- R3: An encoder nibble greater than 9 in a used position sets `bad_digit` and forces `code_out` to 0. In narrow mode, `bcd_in[11:8]` is ignored.
- R4: Wide decode (`dir`=1) of each of the 1000 valid 10-bit codes returns the three digits that encode to it, in the nibble order of R1, with `bad_code`=0.
- R5: A wide code of the form 11111nnxxx with nn≠00 sets `bad_code` and drives `bcd_out` to 0. Exactly 24 of the 1024 patterns are flagged.
- R6: Narrow decode uses only `code_in[6:0]`. It returns the two digits in `bcd_out[7:0]` with `bcd_out[11:8]`=0. Any pattern with leading bits 11 other than 11100xx sets `bad_code` and drives `bcd_out` to 0. Exactly 28 of the 128 patterns are flagged.
- R7: `out_valid` rises exactly one clock after a cycle with `in_valid`=1 and is 0 one clock after a cycle with `in_valid`=0.
- R8: While `rst_n` is low at a rising edge, every output is cleared to 0.
- R9: In encode direction, `bcd_out` and `bad_code` are 0. In decode direction, `code_out` and `bad_digit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| dir | input | 1 | 0 = encode digits, 1 = decode code word |
| narrow | input | 1 | 0 = three digits / 10 bits, 1 = two digits / 7 bits |
| bcd_in | input | 12 | Digits to encode, most significant nibble first |
| code_in | input | 10 | Code word to decode (bits 6:0 in narrow mode) |
| out_valid | output | 1 | Result present |
| code_out | output | 10 | Encoded word |
| bad_digit | output | 1 | Encoder saw a nibble above 9 |
| bcd_out | output | 12 | Decoded digits |
| bad_code | output | 1 | Decoder saw an unused code |

## Verification
Every digit triple and every digit pair is encoded. Because each triple falls in exactly one of the eight class patterns, this sweep separates the prefix selection from the field placement. All 1024 wide and 128 narrow code words are decoded against a table built from the bench's own encoder, which confirms the round trip and also counts the flagged patterns per mode. A few hand-picked nibbles above 9, together with junk in the upper nibble during narrow mode, show that the error flag depends only on the positions in use.

// File: rtl/chd_pkg.sv
// Package: shared widths and digit helpers for the decimal compression codec.
// Assumes digits are 4-bit BCD nibbles; values above 9 are treated as errors.
package chd_pkg;
    localparam int DIG_W      = 4;
    localparam int FLD_W      = DIG_W - 1;
    localparam int WIDE_DIGS  = 3;
    localparam int NAR_DIGS   = 2;
    localparam int WIDE_CODE  = 10;
    localparam int NAR_CODE   = 7;
    localparam int BCD_W      = WIDE_DIGS * DIG_W;
    localparam int CODE_PAD   = WIDE_CODE - NAR_CODE;

    typedef logic [DIG_W-1:0] digit_t;

    // Rebuild a low-class digit (0..7) from its 3-bit field.
    function automatic digit_t low_digit(input logic [FLD_W-1:0] f);
        return {1'b0, f};
    endfunction

    // Rebuild a top-class digit (8 or 9) from its single bit.
    function automatic digit_t top_digit(input logic b);
        return {3'b100, b};
    endfunction
endpackage

// File: rtl/chd_digit_split.sv
// Module: splits one BCD nibble into class bit, field and error flag.
// Assumes nothing beyond a 4-bit input; pure combinational.
module chd_digit_split
    import chd_pkg::*;
(
    input  digit_t             digit,
    output logic               top,
    output logic [FLD_W-1:0]   fld,
    output logic               bad
);
    // Classify the nibble and flag values 10..15.
    always_comb begin
        top = digit[DIG_W-1];
        fld = digit[FLD_W-1:0];
        bad = digit[DIG_W-1] & (digit[2] | digit[1]);
    end
endmodule

// File: rtl/chd_encoder.sv
// Module: packs three digits into 10 bits, or two digits into 7 bits.
// Assumes: narrow mode feeds a zero third digit into the wide layout; the
// narrow code is then the upper seven bits, since the narrow prefixes match.
module chd_encoder
    import chd_pkg::*;
(
    input  logic [BCD_W-1:0]     bcd,
    input  logic                 narrow,
    output logic [WIDE_CODE-1:0] code,
    output logic                 bad
);
    logic [WIDE_DIGS-1:0][DIG_W-1:0] dig;
    logic [WIDE_DIGS-1:0]            hi;
    logic [WIDE_DIGS-1:0][FLD_W-1:0] fld;
    logic [WIDE_DIGS-1:0]            bad_d;
    logic [WIDE_CODE-1:0]            wide;

    // Route nibbles to digit slots depending on the mode.
    always_comb begin
        if (narrow) begin
            dig[2] = bcd[2*DIG_W-1:DIG_W];
            dig[1] = bcd[DIG_W-1:0];
            dig[0] = '0;
        end else begin
            dig[2] = bcd[3*DIG_W-1:2*DIG_W];
            dig[1] = bcd[2*DIG_W-1:DIG_W];
            dig[0] = bcd[DIG_W-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDE_DIGS; gi++) begin : g_split
            chd_digit_split u_split (
                .digit (dig[gi]),
                .top   (hi[gi]),
                .fld   (fld[gi]),
                .bad   (bad_d[gi])
            );
        end
    endgenerate

    // Select the layout from the set of top-class positions.
    always_comb begin
        case (hi)
            3'b000:  wide = {1'b0, fld[2], fld[1], fld[0]};
            3'b100:  wide = {3'b100, fld[2][0], fld[1], fld[0]};
            3'b010:  wide = {3'b101, fld[2], fld[1][0], fld[0]};
            3'b001:  wide = {3'b110, fld[2], fld[1], fld[0][0]};
            3'b110:  wide = {5'b11100, fld[2][0], fld[1][0], fld[0]};
            3'b101:  wide = {5'b11101, fld[2][0], fld[1], fld[0][0]};
            3'b011:  wide = {5'b11110, fld[2], fld[1][0], fld[0][0]};
            default: wide = {7'b1111100, fld[2][0], fld[1][0], fld[0][0]};
        endcase
    end

    // Final word and error; the third slot is a constant zero in narrow mode.
    always_comb begin
        bad  = |bad_d;
        if (bad)
            code = '0;
        else if (narrow)
            code = {{CODE_PAD{1'b0}}, wide[WIDE_CODE-1:CODE_PAD]};
        else
            code = wide;
    end
endmodule

// File: rtl/chd_decoder.sv
// Module: unpacks a 10-bit word to three digits or a 7-bit word to two.
// Assumes: a narrow word is padded with three zero bits and decoded by the
// wide tree; prefixes that only exist in the wide format are rejected.
module chd_decoder
    import chd_pkg::*;
(
    input  logic [WIDE_CODE-1:0] code,
    input  logic                 narrow,
    output logic [BCD_W-1:0]     bcd,
    output logic                 bad
);
    logic [WIDE_CODE-1:0] w;
    digit_t               da, db, dc;
    logic                 wide_ok;
    logic                 nar_ok;

    // Align the narrow word to the top of the wide word.
    always_comb begin
        if (narrow) w = {code[NAR_CODE-1:0], {CODE_PAD{1'b0}}};
        else        w = code;
    end

    // Decode the prefix tree of the wide format.
    always_comb begin
        da = '0; db = '0; dc = '0; wide_ok = 1'b1;
        casez (w)
            10'b0?????????: begin
                da = low_digit(w[8:6]); db = low_digit(w[5:3]); dc = low_digit(w[2:0]);
            end
            10'b100???????: begin
                da = top_digit(w[6]);   db = low_digit(w[5:3]); dc = low_digit(w[2:0]);
            end
            10'b101???????: begin
                da = low_digit(w[6:4]); db = top_digit(w[3]);   dc = low_digit(w[2:0]);
            end
            10'b110???????: begin
                da = low_digit(w[6:4]); db = low_digit(w[3:1]); dc = top_digit(w[0]);
            end
            10'b11100?????: begin
                da = top_digit(w[4]);   db = top_digit(w[3]);   dc = low_digit(w[2:0]);
            end
            10'b11101?????: begin
                da = top_digit(w[4]);   db = low_digit(w[3:1]); dc = top_digit(w[0]);
            end
            10'b11110?????: begin
                da = low_digit(w[4:2]); db = top_digit(w[1]);   dc = top_digit(w[0]);
            end
            10'b1111100???: begin
                da = top_digit(w[2]);   db = top_digit(w[1]);   dc = top_digit(w[0]);
            end
            default: wide_ok = 1'b0;
        endcase
    end

    // Narrow words may only use the four short prefixes.
    always_comb begin
        nar_ok = ~w[9] | (w[9:8] == 2'b10) | (w[9:5] == 5'b11100);
    end

    // Assemble digits; an unused code yields all-zero digits.
    always_comb begin
        bad = narrow ? ~nar_ok : ~wide_ok;
        if (bad)         bcd = '0;
        else if (narrow) bcd = {{DIG_W{1'b0}}, da, db};
        else             bcd = {da, db, dc};
    end
endmodule

// File: rtl/chd_codec.sv
// Module: top of the decimal compression codec. Combinational encoder and
// decoder followed by one register stage; result appears one clock after
// the request. Assumes synchronous active-low reset and one request per cycle.
module chd_codec
    import chd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 dir,
    input  logic                 narrow,
    input  logic [BCD_W-1:0]     bcd_in,
    input  logic [WIDE_CODE-1:0] code_in,
    output logic                 out_valid,
    output logic [WIDE_CODE-1:0] code_out,
    output logic                 bad_digit,
    output logic [BCD_W-1:0]     bcd_out,
    output logic                 bad_code
);
    logic [WIDE_CODE-1:0] enc_code;
    logic                 enc_bad;
    logic [BCD_W-1:0]     dec_bcd;
    logic                 dec_bad;
    logic                 dir_q;
    logic                 narrow_q;

    chd_encoder u_enc (
        .bcd    (bcd_in),
        .narrow (narrow),
        .code   (enc_code),
        .bad    (enc_bad)
    );

    chd_decoder u_dec (
        .code   (code_in),
        .narrow (narrow),
        .bcd    (dec_bcd),
        .bad    (dec_bad)
    );

    // Capture the result of the selected direction; the other side reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            code_out  <= '0;
            bad_digit <= 1'b0;
            bcd_out   <= '0;
            bad_code  <= 1'b0;
            dir_q     <= 1'b0;
            narrow_q  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dir_q     <= dir;
                narrow_q  <= narrow;
                code_out  <= dir ? '0 : enc_code;
                bad_digit <= dir ? 1'b0 : enc_bad;
                bcd_out   <= dir ? dec_bcd : '0;
                bad_code  <= dir ? dec_bad : 1'b0;
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !dir_q && narrow_q) |-> (code_out[9:7] == 3'b000)); // R2
    AST_BAD_ENC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bad_digit) |-> (code_out == '0)); // R3
    AST_BAD_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bad_code) |-> (bcd_out == '0)); // R5
    AST_WIDE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dir_q && !narrow_q) |->
        (bad_code == (($past(code_in[9:5]) == 5'b11111) && ($past(code_in[4:3]) != 2'b00)))); // R5
    AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dir_q && narrow_q) |-> (bcd_out[11:8] == 4'h0)); // R6
    AST_SIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dir_q ? (code_out == '0 && !bad_digit) : (bcd_out == '0 && !bad_code))); // R9
    AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dir_q) |-> (bcd_out[11:8] <= 4'd9 && bcd_out[7:4] <= 4'd9 && bcd_out[3:0] <= 4'd9)); // R4
endmodule

// File: tb/tb_chd_codec.sv
module tb_chd_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir = 1'b0;
    logic        narrow = 1'b0;
    logic [11:0] bcd_in = '0;
    logic [9:0]  code_in = '0;
    logic        out_valid;
    logic [9:0]  code_out;
    logic        bad_digit;
    logic [11:0] bcd_out;
    logic        bad_code;

    always #4 clk = ~clk; // 125 MHz

    chd_codec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir), .narrow(narrow),
        .bcd_in(bcd_in), .code_in(code_in), .out_valid(out_valid), .code_out(code_out),
        .bad_digit(bad_digit), .bcd_out(bcd_out), .bad_code(bad_code)
    );

    typedef struct {
        logic        dir;
        logic        narrow;
        logic [9:0]  code;
        logic        bd;
        logic [11:0] bcd;
        logic        bc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int tests = 0;
    int fails = 0;
    int cnt_bad10 = 0;
    int cnt_bad7 = 0;
    int cycles = 0;
    bit done = 0;

    logic [11:0] tbl10_dig [1024];
    bit          tbl10_ok  [1024];
    logic [11:0] tbl7_dig  [128];
    bit          tbl7_ok   [128];

    // Bench model of the wide layouts (R1).
    function automatic logic [9:0] m_enc10(input int a, input int b, input int c);
        logic [2:0] pa, pb, pc;
        pa = a[2:0]; pb = b[2:0]; pc = c[2:0];
        if (a < 8 && b < 8 && c < 8) return {1'b0, pa, pb, pc};
        if (a >= 8 && b < 8 && c < 8) return {3'b100, pa[0], pb, pc};
        if (a < 8 && b >= 8 && c < 8) return {3'b101, pa, pb[0], pc};
        if (a < 8 && b < 8 && c >= 8) return {3'b110, pa, pb, pc[0]};
        if (c < 8) return {5'b11100, pa[0], pb[0], pc};
        if (b < 8) return {5'b11101, pa[0], pb, pc[0]};
        if (a < 8) return {5'b11110, pa, pb[0], pc[0]};
        return {7'b1111100, pa[0], pb[0], pc[0]};
    endfunction

    // Bench model of the narrow layouts (R2).
    function automatic logic [6:0] m_enc7(input int a, input int b);
        logic [2:0] pa, pb;
        pa = a[2:0]; pb = b[2:0];
        if (a < 8 && b < 8) return {1'b0, pa, pb};
        if (b < 8) return {3'b100, pa[0], pb};
        if (a < 8) return {3'b101, pa, pb[0]};
        return {5'b11100, pa[0], pb[0]};
    endfunction

    task automatic send(input logic d, input logic n, input logic [11:0] b,
                        input logic [9:0] c, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1; dir = d; narrow = n; bcd_in = b; code_in = c;
        q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Monitor: pop the expected item and compare against the outputs.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (q.size() == 0) begin
                check(0, "R7", "result with no request: act out_valid=1 exp 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.dir && bad_code) begin
                    if (e.narrow) cnt_bad7++; else cnt_bad10++;
                end
                check(code_out == e.code && bad_digit == e.bd && bcd_out == e.bcd && bad_code == e.bc,
                      e.tag,
                      $sformatf("act code=%h bd=%0b bcd=%h bc=%0b exp code=%h bd=%0b bcd=%h bc=%0b",
                                code_out, bad_digit, bcd_out, bad_code, e.code, e.bd, e.bcd, e.bc));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: act cycles=%0d exp below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        for (int i = 0; i < 1024; i++) begin tbl10_ok[i] = 0; tbl10_dig[i] = '0; end
        for (int i = 0; i < 128; i++) begin tbl7_ok[i] = 0; tbl7_dig[i] = '0; end
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++) begin
                for (int c = 0; c < 10; c++) begin
                    logic [9:0] w;
                    w = m_enc10(a, b, c);
                    tbl10_ok[w] = 1;
                    tbl10_dig[w] = {a[3:0], b[3:0], c[3:0]};
                end
                tbl7_ok[m_enc7(a, b)] = 1;
                tbl7_dig[m_enc7(a, b)] = {4'h0, a[3:0], b[3:0]};
            end

        // R8: reset clears outputs even with a request present.
        in_valid = 1'b1; bcd_in = 12'h999;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && code_out == 0 && bcd_out == 0 && !bad_digit && !bad_code, "R8",
              $sformatf("act v=%0b code=%h bcd=%h exp all zero", out_valid, code_out, bcd_out));
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1, R9: every triple, wide encode.
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 10; c++) begin
                    e = '{dir:0, narrow:0, code:m_enc10(a, b, c), bd:0, bcd:'0, bc:0, tag:"R1"};
                    send(0, 0, {a[3:0], b[3:0], c[3:0]}, 10'h3FF, e);
                end
        // R2, R3: every pair, narrow encode with junk in the unused nibble.
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++) begin
                e = '{dir:0, narrow:1, code:{3'b000, m_enc7(a, b)}, bd:0, bcd:'0, bc:0, tag:"R2"};
                send(0, 1, {4'hF, a[3:0], b[3:0]}, 10'h000, e);
            end
        // R3: illegal nibbles in used positions.
        e = '{dir:0, narrow:0, code:'0, bd:1, bcd:'0, bc:0, tag:"R3"};
        send(0, 0, 12'hA00, 0, e);
        send(0, 0, 12'h0F5, 0, e);
        send(0, 0, 12'h09B, 0, e);
        e.narrow = 1;
        send(0, 1, 12'h0A0, 0, e);
        send(0, 1, 12'h01C, 0, e);
        // R4, R5, R9: every wide code word.
        for (int w = 0; w < 1024; w++) begin
            e = '{dir:1, narrow:0, code:'0, bd:0, bcd:tbl10_dig[w], bc:!tbl10_ok[w],
                  tag:(tbl10_ok[w] ? "R4" : "R5")};
            send(1, 0, 12'hFFF, w[9:0], e);
        end
        // R6: every narrow code word, with junk above bit 6.
        for (int w = 0; w < 128; w++) begin
            e = '{dir:1, narrow:1, code:'0, bd:0, bcd:tbl7_dig[w], bc:!tbl7_ok[w], tag:"R6"};
            send(1, 1, 12'h000, {3'b111, w[6:0]}, e);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R7: idle input gives no result.
        check(out_valid == 0 && q.size() == 0, "R7",
              $sformatf("act v=%0b pending=%0d exp 0/0", out_valid, q.size()));
        check(cnt_bad10 == 24, "R5", $sformatf("act flagged=%0d exp 24", cnt_bad10));
        check(cnt_bad7 == 28, "R6", $sformatf("act flagged=%0d exp 28", cnt_bad7));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule